// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block drives a 12-bit successive-approximation converter that has a three-wire serial port. The port has an active-low select line, a data clock that the controller generates, and a single data return line. The converter has no clock of its own. The controller's data clock paces the conversion, so each result bit appears on the return line while the conversion is still running. A frame opens with the select line falling. Two clock periods of sampling follow. The converter then sends one low null bit, and after it the result, most significant bit first. If the clock keeps running, the converter sends the result a second time in reverse order, least significant bit first, and then goes quiet.

A host pulses `start` with a requested bit count and a verify choice. The controller runs one frame and returns a left-aligned result with a one-cycle valid strobe and an error flag. The frame can be cut short after any number of result bits, which saves converter power when only a coarse value is needed. When the full 12 bits are requested, the controller can also clock out the reversed repeat and compare it with the first copy. All timing is counted in system clocks. Each half period of the data clock lasts `HALF_DIV` system clocks, and the select line stays high for `CS_GAP` cycles between frames.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is asserted and directly after it is released, `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0, `result_valid` is 0, `result_err` is 0 and `result` is 0.
- R2: A `start` pulse seen while idle drives `adc_cs_n` low. `adc_sclk` then stays low for exactly `HALF_DIV` system clocks before its first rise. From then on, every high and every low level of `adc_sclk` lasts exactly `HALF_DIV` system clocks.
- R3: Rising edges of `adc_sclk` are numbered from 1 after `adc_cs_n` falls. Rise 3 samples the null bit. Rises 4 through 15 sample result bits 11 down to 0, and the bit sampled at rise k lands in `result[15-k]`.
- R4: `bit_count` is latched at `start`. The values 1 to 12 select N. The values 0 and 13 to 15 select 12. A frame without verify ends after rise 3+N. `result` then holds the N captured bits in its top N positions, and the bits below them are 0.
- R5: If the null bit sampled at rise 3 is 1, `result_err` is 1 together with that frame's `result_valid`.
- R6: When `verify_en` is 1 at `start` and N is 12, the frame continues to rise 26. Rises 16 through 26 sample the repeated bits 1 through 11, with bit j taken at rise 15+j. `result_err` is set if any repeated bit differs from the same bit of the first copy.
- R7: When N is below 12, `verify_en` has no effect. The frame ends after rise 3+N, and `result_err` depends only on the null bit.
- R8: `result_valid` is a single-cycle pulse in the cycle in which `adc_cs_n` returns high. `result` and `result_err` hold their values until the next pulse.
- R9: `start` is ignored while `busy` is 1, and `bit_count` and `verify_en` may change freely during a frame. After a frame ends, `busy` stays 1 for exactly `CS_GAP` cycles, counting the `result_valid` cycle. `adc_cs_n` stays high for at least that long.
- R10: `adc_sclk` is low whenever `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| bit_count | input | 4 | Requested result length; 0 or above 12 means 12 |
| verify_en | input | 1 | Capture and compare the reversed repeat (full length only) |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low select to the converter |
| adc_sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| result_valid | output | 1 | One-cycle strobe at end of frame |
| result | output | 12 | Left-aligned, zero-filled conversion result |
| result_err | output | 1 | Null-bit or repeat-mismatch error for the frame |

## Verification
The bench targets the off-by-one edges of the frame. If the null bit is taken one rise too early or too late, every result shifts by one bit, and any pattern other than all-ones or all-zeros fails. Truncation to one bit, together with the out-of-range lengths 0 and 13 to 15, catches a clamp or end-of-frame compare that is off by one. A single flipped bit in the reversed repeat, with bit 11 and bit 1 among the choices, exposes a compare that skips the edge positions. The same corruption with a short frame catches a design that still checks the repeat or lengthens the frame. A `start` pulse in the middle of a frame shows whether a busy controller restarts the converter.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  // Frame phase of the readout sequencer.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_RUN   = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;

  // Rise number (counted from select low) that carries the null bit.
  localparam int unsigned NULL_RISE = 3;

endpackage

// File: rtl/sar_rd_pace.sv
module sar_rd_pace #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int unsigned RISE_W = 5,
  parameter int unsigned CS_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [RISE_W-1:0] last_rise,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              accept,
  output logic              pace_en,
  output logic              sample,
  output logic              frame_end,
  output logic [RISE_W-1:0] rise_idx
);
  localparam int unsigned GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

  phase_e            phase_q, phase_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic [RISE_W-1:0] rise_q, rise_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  always_comb begin
    phase_d   = phase_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    rise_d    = rise_q;
    gap_d     = gap_q;
    sample    = 1'b0;
    frame_end = 1'b0;
    accept    = (phase_q == PH_IDLE) && start;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cs_d    = 1'b0;
          rise_d  = '0;
        end
      end
      PH_SETUP: begin
        if (tick) begin
          phase_d = PH_RUN;
          sclk_d  = 1'b1;
          rise_d  = rise_q + 1'b1;
          sample  = 1'b1;
        end
      end
      PH_RUN: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
            if (rise_q == last_rise) begin
              frame_end = 1'b1;
              cs_d      = 1'b1;
              phase_d   = PH_GAP;
              gap_d     = '0;
            end
          end else begin
            sclk_d = 1'b1;
            rise_d = rise_q + 1'b1;
            sample = 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (gap_q == GAP_LAST) phase_d = PH_IDLE;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      rise_q  <= '0;
      gap_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      rise_q  <= rise_d;
      gap_q   <= gap_d;
    end
  end

  assign cs_n     = cs_q;
  assign sclk     = sclk_q;
  assign busy     = (phase_q != PH_IDLE);
  assign pace_en  = (phase_q == PH_SETUP) || (phase_q == PH_RUN);
  assign rise_idx = rise_q + 1'b1;
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
  import sar_rd_pkg::*;
#(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned RISE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [RISE_W-1:0] rise_idx,
  input  logic              sdo,
  output logic [RES_W-1:0]  word,
  output logic              null_bad,
  output logic              mismatch
);
  logic [RES_W-1:0] word_q;
  logic [RES_W-1:0] word_ld;
  logic [RES_W-1:1] rep_q;
  logic [RES_W-1:1] rep_ld;
  logic             null_q;
  logic             null_ld;

  // First copy: result bit b arrives on rise RES_W+3-b.
  for (genvar b = 0; b < RES_W; b++) begin : g_first
    localparam logic [RISE_W-1:0] AT = RISE_W'(RES_W + NULL_RISE - b);
    assign word_ld[b] = sample && (rise_idx == AT);
  end

  // Reversed repeat: bit b arrives on rise RES_W+3+b.
  for (genvar b = 1; b < RES_W; b++) begin : g_repeat
    localparam logic [RISE_W-1:0] AT = RISE_W'(RES_W + NULL_RISE + b);
    assign rep_ld[b] = sample && (rise_idx == AT);
  end

  assign null_ld = sample && (rise_idx == RISE_W'(NULL_RISE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rep_q  <= '0;
      null_q <= 1'b0;
    end else if (clear) begin
      word_q <= '0;
      rep_q  <= '0;
      null_q <= 1'b0;
    end else begin
      for (int b = 0; b < RES_W; b++)
        if (word_ld[b]) word_q[b] <= sdo;
      for (int b = 1; b < RES_W; b++)
        if (rep_ld[b]) rep_q[b] <= sdo;
      if (null_ld) null_q <= sdo;
    end
  end

  assign word     = word_q;
  assign null_bad = null_q;
  assign mismatch = (rep_q != word_q[RES_W-1:1]);
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int unsigned RES_W    = 12,
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned CS_GAP   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(RES_W+1)-1:0]   bit_count,
  input  logic                         verify_en,
  input  logic                         adc_sdo,
  output logic                         adc_cs_n,
  output logic                         adc_sclk,
  output logic                         busy,
  output logic                         result_valid,
  output logic [RES_W-1:0]             result,
  output logic                         result_err
);
  localparam int unsigned CNT_W     = $clog2(RES_W + 1);
  localparam int unsigned LAST_FULL = 2 * RES_W + NULL_RISE - 1;
  localparam int unsigned RISE_W    = $clog2(LAST_FULL + 1);

  logic              tick, pace_en, accept, sample, frame_end;
  logic [RISE_W-1:0] rise_idx, last_rise;
  logic [RES_W-1:0]  word;
  logic              null_bad, mismatch;

  logic [CNT_W-1:0]  n_eff_q, n_eff_d, n_req;
  logic              ver_q, ver_d;
  logic              valid_q, valid_d, err_q, err_d;
  logic [RES_W-1:0]  res_q, res_d;

  // Length clamp and frame-length selection.
  always_comb begin
    n_req   = (bit_count == '0 || bit_count > CNT_W'(RES_W)) ? CNT_W'(RES_W) : bit_count;
    n_eff_d = accept ? n_req : n_eff_q;
    ver_d   = accept ? (verify_en && (n_req == CNT_W'(RES_W))) : ver_q;
    last_rise = ver_q ? RISE_W'(LAST_FULL)
                      : RISE_W'(NULL_RISE) + RISE_W'(n_eff_q);
  end

  // Result publication at end of frame.
  always_comb begin
    valid_d = frame_end;
    res_d   = frame_end ? word : res_q;
    err_d   = frame_end ? (null_bad || (ver_q && mismatch)) : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_eff_q <= CNT_W'(RES_W);
      ver_q   <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      n_eff_q <= n_eff_d;
      ver_q   <= ver_d;
      valid_q <= valid_d;
      res_q   <= res_d;
      err_q   <= err_d;
    end
  end

  sar_rd_pace #(.HALF_DIV(HALF_DIV)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pace_en),
    .tick (tick)
  );

  sar_rd_seq #(.RISE_W(RISE_W), .CS_GAP(CS_GAP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .last_rise(last_rise),
    .cs_n     (adc_cs_n),
    .sclk     (adc_sclk),
    .busy     (busy),
    .accept   (accept),
    .pace_en  (pace_en),
    .sample   (sample),
    .frame_end(frame_end),
    .rise_idx (rise_idx)
  );

  sar_rd_capture #(.RES_W(RES_W), .RISE_W(RISE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .sample  (sample),
    .rise_idx(rise_idx),
    .sdo     (adc_sdo),
    .word    (word),
    .null_bad(null_bad),
    .mismatch(mismatch)
  );

  assign result_valid = valid_q;
  assign result       = res_q;
  assign result_err   = err_q;
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk #(
  parameter int unsigned RES_W    = 12,
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned CS_GAP   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       adc_cs_n,
  input logic                       adc_sclk,
  input logic                       busy,
  input logic                       result_valid,
  input logic [RES_W-1:0]           result,
  input logic [$clog2(RES_W+1)-1:0] n_sel
);
  localparam int unsigned RW = $clog2(HALF_DIV + 1);

  logic          sclk_q;
  logic [RW-1:0] run_q;
  logic [RES_W-1:0] low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sclk_q <= adc_sclk;
      if (adc_sclk != sclk_q)            run_q <= '0;
      else if (run_q != RW'(HALF_DIV))   run_q <= run_q + 1'b1;
    end
  end

  always_comb low_mask = RES_W'((33'd1 << (RES_W - int'(n_sel))) - 33'd1);

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk); // R10
  AST_SCLK_LEVEL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk != sclk_q) |-> (run_q >= RW'(HALF_DIV - 1))); // R2
  AST_VALID_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(adc_cs_n)); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R8
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n); // R9
  AST_BUSY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy); // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ((result & low_mask) == '0)); // R4
endmodule

bind sar_adc_reader sar_adc_reader_chk #(
  .RES_W(RES_W), .HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_cs_n    (adc_cs_n),
  .adc_sclk    (adc_sclk),
  .busy        (busy),
  .result_valid(result_valid),
  .result      (result),
  .n_sel       (n_eff_q)
);

// File: tb/sar_adc_reader_test.sv
`timescale 1ns/1ps
module sar_adc_reader_test;
  localparam int RES_W    = 12;
  localparam int HALF_DIV = 4;
  localparam int CS_GAP   = 4;
  localparam int CNT_W    = $clog2(RES_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] bit_count = '0;
  logic verify_en = 1'b0;
  logic adc_sdo;
  logic adc_cs_n, adc_sclk, busy, result_valid, result_err;
  logic [RES_W-1:0] result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sar_adc_reader #(.RES_W(RES_W), .HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
    .verify_en(verify_en), .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .busy(busy), .result_valid(result_valid),
    .result(result), .result_err(result_err));

  // ---------------- converter model ----------------
  logic [RES_W-1:0] m_code = '0;
  bit m_bad_null = 1'b0;
  int m_flip = 0;
  int fall_total = 0, fall_base = 0;
  int rise_total = 0, rise_base = 0;
  int cs_falls = 0;

  always @(negedge adc_sclk) fall_total = fall_total + 1;
  always @(posedge adc_sclk) rise_total = rise_total + 1;
  always @(negedge adc_cs_n) begin
    fall_base = fall_total;
    rise_base = rise_total;
    cs_falls  = cs_falls + 1;
  end

  function automatic logic model_bit(int f, logic [RES_W-1:0] code, bit bad, int flip);
    if (f == 2) return bad;
    if (f >= 3 && f <= RES_W + 2) return code[RES_W + 2 - f];
    if (f >= RES_W + 3 && f <= 2 * RES_W + 1)
      return code[f - RES_W - 2] ^ (flip == f - RES_W - 2);
    return 1'b1;
  endfunction

  assign adc_sdo = adc_cs_n ? 1'b1 : model_bit(fall_total - fall_base, m_code, m_bad_null, m_flip);

  // ---------------- clock-level monitor ----------------
  bit prev_cs = 1'b1, prev_sclk = 1'b0, seen_rise = 1'b0;
  int run_len = 0, min_run = 0, setup_len = 0;

  always @(negedge clk) begin
    if (prev_cs && !adc_cs_n) begin
      min_run = 9999; setup_len = 0; seen_rise = 1'b0;
    end
    if (!adc_cs_n) begin
      if (adc_sclk != prev_sclk) begin
        if (seen_rise && run_len < min_run) min_run = run_len;
        if (adc_sclk) seen_rise = 1'b1;
        run_len = 1;
      end else begin
        run_len = run_len + 1;
      end
      if (!seen_rise && !adc_sclk) setup_len = setup_len + 1;
    end
    prev_cs   = adc_cs_n;
    prev_sclk = adc_sclk;
  end

  // ---------------- checking helpers ----------------
  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(int n);
    return (n == 0 || n > RES_W) ? RES_W : n;
  endfunction

  function automatic logic [RES_W-1:0] exp_result(logic [RES_W-1:0] code, int n);
    logic [RES_W-1:0] keep;
    keep = ~RES_W'((33'd1 << (RES_W - eff_len(n))) - 33'd1);
    return code & keep;
  endfunction

  task automatic run_frame(logic [RES_W-1:0] code, int n, bit ver, bit bad, int flip, bit poke);
    int ne, exp_rises, falls0, busy_cnt;
    bit exp_err, got;
    ne = eff_len(n);
    exp_rises = (ver && ne == RES_W) ? 2 * RES_W + 2 : 3 + ne;
    exp_err = bad || (ver && ne == RES_W && flip != 0);
    m_code = code; m_bad_null = bad; m_flip = flip;
    falls0 = cs_falls;
    @(negedge clk);
    start = 1'b1; bit_count = CNT_W'(n); verify_en = ver;
    @(negedge clk);
    start = 1'b0;
    bit_count = CNT_W'($urandom % 16); verify_en = ~ver;  // R9: changes during frame
    if (poke) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (result_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check("R8", "valid seen", got, 1);
    check("R3_R4", "result", result, exp_result(code, n));
    check(ne < RES_W ? "R7" : (flip != 0 ? "R6" : "R5"), "err", result_err, exp_err);
    check(ver && ne < RES_W ? "R7" : "R4_R6", "rise count", rise_total - rise_base, exp_rises);
    check("R2", "setup low", setup_len, HALF_DIV);
    check("R2", "min level", min_run, HALF_DIV);
    check("R9", "one select", cs_falls - falls0, 1);
    busy_cnt = 0;
    for (int i = 0; i < 50; i++) begin
      if (!busy) break;
      busy_cnt++;
      @(negedge clk);
      check("R8", "valid pulse width", result_valid, 0);
    end
    check("R9", "gap busy", busy_cnt, CS_GAP);
    check("R8", "result held", result, exp_result(code, n));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R1", "cs_n in reset", adc_cs_n, 1);
    check("R1", "sclk in reset", adc_sclk, 0);
    check("R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", result_valid, 0);
    check("R1", "err after reset", result_err, 0);
    check("R1", "result after reset", result, 0);
    check("R10", "sclk idle", adc_sclk, 0);

    run_frame(12'hFFF, 12, 0, 0, 0, 0);
    run_frame(12'h000, 12, 1, 0, 0, 0);
    run_frame(12'h800, 12, 1, 0, 0, 0);
    run_frame(12'hA5C, 12, 1, 0, 0, 0);
    run_frame(12'h7FF, 1, 0, 0, 0, 0);   // R4 one bit
    run_frame(12'hC3A, 0, 0, 0, 0, 0);   // R4 zero means full
    run_frame(12'h3C5, 15, 0, 0, 0, 0);  // R4 above range means full
    run_frame(12'h9B6, 7, 0, 1, 0, 0);   // R5 null high
    run_frame(12'h5A3, 12, 1, 0, 11, 0); // R6 repeat MSB corrupted
    run_frame(12'h5A3, 12, 1, 0, 1, 0);  // R6 repeat bit 1 corrupted
    run_frame(12'h5A3, 12, 0, 0, 4, 0);  // R6 no verify: repeat ignored
    run_frame(12'hE21, 8, 1, 0, 3, 0);   // R7 verify ignored when short
    run_frame(12'h6D2, 12, 1, 0, 0, 1);  // R9 start while busy
    for (int k = 0; k < 40; k++) begin
      run_frame(RES_W'($urandom), int'($urandom % 16), bit'($urandom % 2),
                ($urandom % 8) == 0, (($urandom % 4) == 0) ? 1 + int'($urandom % 11) : 0,
                ($urandom % 5) == 0);
    end
    repeat (5) @(negedge clk);
    check("R10", "sclk parked at end", adc_sclk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule